// File: doc/BRIEF.md
# Sector ECC Correction Patcher

This block finishes the read of one flash sector once its data bytes are in a local sector buffer. A four-symbol ECC decoder beside it raises a done flag when it has results. A plain done means the decoder has produced three correction words, and each word names a byte and gives an XOR mask. Done together with a fail flag means the sector cannot be corrected. The patcher applies each mask to its byte with a read-modify-write of the buffer. It then pulses a clear strobe so the decoder can carry on.

When the decoder reports an uncorrectable sector, the block scans that sector for any byte other than 0xFF. It reads one byte per clock and stops at the first non-0xFF byte. A sector that holds only 0xFF is taken to be erased, so its failure is ignored. A sector is finished when the spare-data FIFO reports exactly four words. The block then reports one outcome and says whether the 16 spare bytes may be read out. A cycle limit ends a sector that never finishes.

The buffer holds four 512-byte sectors. In large-page mode the sector number selects a 512-byte window. In small-page mode the byte offset is used as given. When the block is idle, a host byte port loads the buffer and reads it back.

Top module: `ecc_sector_patcher`

## Requirements
- R1: After reset `busy`, `eccClear`, `outDone` and `spareRelease` are all low.
- R2: A correction word carries the byte offset in bits 31:16 and the XOR mask in bits 7:0. Bits 15:8 are ignored. The addressed byte becomes its old value XOR the mask.
- R3: In large-page mode (`largePage`=1) a patch goes to 512×`sectorIdx` + offset. In small-page mode the offset is the buffer address and `sectorIdx` is ignored. The address wraps modulo the buffer size.
- R4: Each correction event applies all three words of `eccResult`, in the order word 0 (bits 31:0), word 1, word 2. Each patch takes two cycles. When two words name the same byte, both masks are applied.
- R5: An uncorrectable event on a sector that holds only 0xFF does not mark the sector as failed.
- R6: An uncorrectable event on a sector with a non-0xFF byte marks it failed. The scan reads one byte per clock and stops at the first non-0xFF byte.
- R7: After each event has been handled, `eccClear` is high for exactly one cycle.
- R8: A sector finishes only when `spareCount` equals 4. Any other count keeps it waiting.
- R9: `outDone` is a one-cycle pulse with `outcome` coded 0 = success, 1 = repaired, 2 = error, 3 = timeout. In the same cycle `spareRelease` is high for every outcome except error.
- R10: A sector not finished within `TIMEOUT_CYCLES` cycles of `start` ends with outcome 3.
- R11: Host writes while `busy` is high leave the buffer unchanged.
- R12: The outcome is error if any scan found data, otherwise repaired if any correction event was applied, otherwise success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin handling a sector (honoured when idle) |
| largePage | input | 1 | 1 = offsets are relative to the sector's 512-byte window |
| sectorIdx | input | 2 | Sector number within the page |
| eccDone | input | 1 | Decoder has a result |
| eccFail | input | 1 | With eccDone: the sector is uncorrectable |
| eccResult | input | 96 | Three packed correction words, word 0 in bits 31:0 |
| spareCount | input | 8 | Words available in the spare-data FIFO |
| hostEn | input | 1 | Host buffer access strobe |
| hostWe | input | 1 | Host access is a write |
| hostAddr | input | 11 | Host byte address |
| hostWdata | input | 8 | Host write byte |
| hostRdata | output | 8 | Byte read, valid the cycle after the access while idle |
| busy | output | 1 | A sector is being handled |
| eccClear | output | 1 | Acknowledge to the decoder after an event |
| outDone | output | 1 | Outcome valid pulse |
| outcome | output | 2 | Sector outcome code |
| spareRelease | output | 1 | Spare bytes may be read out |

## Verification
The state hardest to reach from the ports is a sector that is uncorrectable and yet also leads to a correction. Another is an erased-sector scan that runs the full 512 bytes when the buffer has already been modified by earlier patches. The stimulus fills the buffer with runs of 0xFF and a single planted non-0xFF byte. A decoder model in the bench answers each `eccClear` by dropping its flag and can follow a correction event with a fail event in the same sector. This produces a repaired-then-failed case and a scan that stops after exactly 41 bytes. The spare count is held at 3 and then 5 before 4 so the bench can see that the sector waits. A sector with no events and no spare words runs into the cycle limit.

// File: rtl/ecc_patch_pkg.sv
package ecc_patch_pkg;
  localparam int PATCH_SLOTS = 3;

  typedef enum logic [1:0] {
    OUT_OK      = 2'd0,
    OUT_FIXED   = 2'd1,
    OUT_BAD     = 2'd2,
    OUT_TIMEOUT = 2'd3
  } outcome_e;

  typedef struct packed {
    logic       capture;
    logic       latch;
    logic       patchRd;
    logic       patchWr;
    logic [1:0] slot;
    logic       scanInit;
    logic       scanRun;
  } dpStrobe_t;
endpackage

// File: rtl/ecc_patch_datapath.sv
module ecc_patch_datapath
  import ecc_patch_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int SECTORS      = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  dpStrobe_t                       str,
  input  logic                            busy,
  input  logic                            largePage,
  input  logic [$clog2(SECTORS)-1:0]      sectorIdx,
  input  logic [PATCH_SLOTS*32-1:0]       eccResult,
  input  logic                            hostEn,
  input  logic                            hostWe,
  input  logic [$clog2(SECTORS*SECTOR_BYTES)-1:0] hostAddr,
  input  logic [7:0]                      hostWdata,
  output logic [7:0]                      hostRdata,
  output logic                            scanBad,
  output logic                            scanClean
);
  localparam int BUF_BYTES = SECTOR_BYTES * SECTORS;
  localparam int AW   = $clog2(BUF_BYTES);
  localparam int SW   = $clog2(SECTOR_BYTES);
  localparam int SECW = $clog2(SECTORS);

  logic [7:0]      bufMem [BUF_BYTES];
  logic [7:0]      rdData;
  logic [SECW-1:0] secQ;
  logic            largeQ;
  logic [AW-1:0]   offQ  [4];
  logic [7:0]      patQ  [4];
  logic [AW-1:0]   patchAddr [4];
  logic [AW-1:0]   base, scanAddr, rdAddr, wrAddr;
  logic [SW-1:0]   scanPtr;
  logic            scanValid, scanLastQ;
  logic            memWe;
  logic [7:0]      memWdata;

  logic unusedResBits;
  assign unusedResBits = ^eccResult;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secQ   <= '0;
      largeQ <= 1'b0;
    end else if (str.capture) begin
      secQ   <= sectorIdx;
      largeQ <= largePage;
    end
  end

  assign base = largeQ ? {secQ, {SW{1'b0}}} : '0;

  for (genvar k = 0; k < 4; k++) begin : g_slot
    if (k < PATCH_SLOTS) begin : g_live
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          offQ[k] <= '0;
          patQ[k] <= '0;
        end else if (str.latch) begin
          offQ[k] <= eccResult[k*32+16 +: AW];
          patQ[k] <= eccResult[k*32 +: 8];
        end
      end
    end else begin : g_tie
      assign offQ[k] = '0;
      assign patQ[k] = '0;
    end
    assign patchAddr[k] = base + offQ[k];
  end

  // erased-sector scan: address issued one cycle, byte compared the next
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scanPtr   <= '0;
      scanValid <= 1'b0;
      scanLastQ <= 1'b0;
    end else if (str.scanInit) begin
      scanPtr   <= '0;
      scanValid <= 1'b0;
      scanLastQ <= 1'b0;
    end else if (str.scanRun) begin
      scanPtr   <= scanPtr + 1'b1;
      scanValid <= 1'b1;
      scanLastQ <= (scanPtr == SW'(SECTOR_BYTES - 1));
    end else begin
      scanValid <= 1'b0;
    end
  end

  assign scanAddr  = base + AW'(scanPtr);
  assign scanBad   = str.scanRun && scanValid && (rdData != 8'hFF);
  assign scanClean = str.scanRun && scanValid && scanLastQ && (rdData == 8'hFF);

  // buffer port arbitration: the engine owns the RAM while busy
  always_comb begin
    if (str.patchRd)   rdAddr = patchAddr[str.slot];
    else if (busy)     rdAddr = scanAddr;
    else               rdAddr = hostAddr;
    wrAddr   = str.patchWr ? patchAddr[str.slot] : hostAddr;
    memWdata = str.patchWr ? (rdData ^ patQ[str.slot]) : hostWdata;
    memWe    = str.patchWr || (!busy && hostEn && hostWe);
  end

  always_ff @(posedge clk) begin
    if (memWe) bufMem[wrAddr] <= memWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= bufMem[rdAddr];
  end

  assign hostRdata = rdData;

  // R2: written byte equals the byte read before it XOR the slot's mask
  assert_patch_xor_R2: assert property (@(posedge clk) disable iff (!rstN)
    str.patchWr |=> bufMem[$past(wrAddr)] == ($past(rdData) ^ $past(patQ[str.slot])));
endmodule

// File: rtl/ecc_patch_ctrl.sv
module ecc_patch_ctrl
  import ecc_patch_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 2000,
  parameter int SPARE_WORDS    = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       eccDone,
  input  logic       eccFail,
  input  logic [7:0] spareCount,
  input  logic       scanBad,
  input  logic       scanClean,
  output dpStrobe_t  str,
  output logic       busy,
  output logic       eccClear,
  output logic       outDone,
  output logic [1:0] outcome,
  output logic       spareRelease
);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_RD, S_WR, S_SCAN, S_CLEAR} state_e;

  state_e       state;
  logic [1:0]   slot;
  logic [TW-1:0] timer;
  logic         fixedSeen, failedSeen;
  logic         spareReady, expired, evtOk, evtFail;

  assign spareReady = (spareCount == 8'(SPARE_WORDS));
  assign expired    = (timer >= TW'(TIMEOUT_CYCLES));
  assign evtOk      = (state == S_WAIT) && !spareReady && !expired && eccDone && !eccFail;
  assign evtFail    = (state == S_WAIT) && !spareReady && !expired && eccDone && eccFail;

  always_comb begin
    str          = '0;
    str.capture  = (state == S_IDLE) && start;
    str.latch    = evtOk;
    str.scanInit = evtFail;
    str.patchRd  = (state == S_RD);
    str.patchWr  = (state == S_WR);
    str.slot     = slot;
    str.scanRun  = (state == S_SCAN);
  end

  assign busy     = (state != S_IDLE);
  assign eccClear = (state == S_CLEAR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= S_IDLE;
      slot         <= '0;
      timer        <= '0;
      fixedSeen    <= 1'b0;
      failedSeen   <= 1'b0;
      outDone      <= 1'b0;
      outcome      <= OUT_OK;
      spareRelease <= 1'b0;
    end else begin
      outDone      <= 1'b0;
      spareRelease <= 1'b0;
      if (state != S_IDLE && !expired) timer <= timer + 1'b1;
      case (state)
        S_IDLE: if (start) begin
          state      <= S_WAIT;
          timer      <= '0;
          fixedSeen  <= 1'b0;
          failedSeen <= 1'b0;
        end
        S_WAIT: begin
          if (spareReady) begin
            outDone      <= 1'b1;
            outcome      <= failedSeen ? OUT_BAD : (fixedSeen ? OUT_FIXED : OUT_OK);
            spareRelease <= !failedSeen;
            state        <= S_IDLE;
          end else if (expired) begin
            outDone      <= 1'b1;
            outcome      <= OUT_TIMEOUT;
            spareRelease <= 1'b1;
            state        <= S_IDLE;
          end else if (evtOk) begin
            slot  <= '0;
            state <= S_RD;
          end else if (evtFail) begin
            state <= S_SCAN;
          end
        end
        S_RD: state <= S_WR;
        S_WR: begin
          if (slot == 2'(PATCH_SLOTS - 1)) begin
            fixedSeen <= 1'b1;
            state     <= S_CLEAR;
          end else begin
            slot  <= slot + 1'b1;
            state <= S_RD;
          end
        end
        S_SCAN: begin
          if (scanBad) begin
            failedSeen <= 1'b1;
            state      <= S_CLEAR;
          end else if (scanClean) begin
            state <= S_CLEAR;
          end
        end
        S_CLEAR: state <= S_WAIT;
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_clear_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    eccClear |=> !eccClear);
  assert_finish_spare_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outDone && outcome != OUT_TIMEOUT) |-> $past(spareCount) == 8'(SPARE_WORDS));
  assert_release_rule_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outDone && outcome == OUT_BAD) |-> !spareRelease);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    outDone |-> !busy);
  assert_timeout_limit_R10: assert property (@(posedge clk) disable iff (!rstN)
    (outDone && outcome == OUT_TIMEOUT) |-> $past(timer) == TW'(TIMEOUT_CYCLES));
endmodule

// File: rtl/ecc_sector_patcher.sv
module ecc_sector_patcher
  import ecc_patch_pkg::*;
#(
  parameter int SECTOR_BYTES   = 512,
  parameter int SECTORS        = 4,
  parameter int TIMEOUT_CYCLES = 2000,
  parameter int SPARE_WORDS    = 4
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  logic                                    start,
  input  logic                                    largePage,
  input  logic [$clog2(SECTORS)-1:0]              sectorIdx,
  input  logic                                    eccDone,
  input  logic                                    eccFail,
  input  logic [PATCH_SLOTS*32-1:0]               eccResult,
  input  logic [7:0]                              spareCount,
  input  logic                                    hostEn,
  input  logic                                    hostWe,
  input  logic [$clog2(SECTORS*SECTOR_BYTES)-1:0] hostAddr,
  input  logic [7:0]                              hostWdata,
  output logic [7:0]                              hostRdata,
  output logic                                    busy,
  output logic                                    eccClear,
  output logic                                    outDone,
  output logic [1:0]                              outcome,
  output logic                                    spareRelease
);
  dpStrobe_t str;
  logic      scanBad, scanClean;

  ecc_patch_ctrl #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES), .SPARE_WORDS(SPARE_WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .eccDone(eccDone), .eccFail(eccFail),
    .spareCount(spareCount), .scanBad(scanBad), .scanClean(scanClean), .str(str),
    .busy(busy), .eccClear(eccClear), .outDone(outDone), .outcome(outcome),
    .spareRelease(spareRelease));

  ecc_patch_datapath #(.SECTOR_BYTES(SECTOR_BYTES), .SECTORS(SECTORS)) u_dp (
    .clk(clk), .rstN(rstN), .str(str), .busy(busy), .largePage(largePage),
    .sectorIdx(sectorIdx), .eccResult(eccResult), .hostEn(hostEn), .hostWe(hostWe),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .scanBad(scanBad), .scanClean(scanClean));
endmodule

// File: tb/ecc_sector_patcher_tb.sv
module ecc_sector_patcher_tb;
  localparam int LIMIT = 2000;
  localparam int BUFN  = 2048;

  logic clk = 1'b0, rstN = 1'b0;
  logic start = 0, largePage = 0, eccDone = 0, eccFail = 0;
  logic [1:0] sectorIdx = 0;
  logic [95:0] eccResult = '0;
  logic [7:0] spareCount = 0;
  logic hostEn = 0, hostWe = 0;
  logic [10:0] hostAddr = 0;
  logic [7:0] hostWdata = 0;
  logic [7:0] hostRdata;
  logic busy, eccClear, outDone, spareRelease;
  logic [1:0] outcome;

  always #4 clk = ~clk;

  ecc_sector_patcher #(.TIMEOUT_CYCLES(LIMIT)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .largePage(largePage), .sectorIdx(sectorIdx),
    .eccDone(eccDone), .eccFail(eccFail), .eccResult(eccResult), .spareCount(spareCount),
    .hostEn(hostEn), .hostWe(hostWe), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .busy(busy), .eccClear(eccClear), .outDone(outDone),
    .outcome(outcome), .spareRelease(spareRelease));

  int compared = 0, mismatched = 0;
  bit summaryDone = 0;
  string reqTag = "R1";

  // ---------------- reference model ----------------
  byte unsigned gold [BUFN];
  int mState = 0, mT = 0, mCnt = 0, mSec = 0;
  bit mRep = 0, mErr = 0, mLarge = 0;
  bit expBusy = 0, expClear = 0, expDone = 0, expRel = 0;
  int expOut = 0;

  function automatic byte unsigned initByte(int a);
    if (a < 40) return 8'hFF;
    if (a == 40) return 8'h12;
    if (a >= 512 && a < 1024) return 8'hFF;
    return 8'((a * 7 + 3) & 255);
  endfunction

  function automatic int firstDirty(int base);
    for (int i = 0; i < 512; i++) if (gold[base + i] != 8'hFF) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; expBusy = 0; expClear = 0; expDone = 0;
    end else begin
      expDone = 0;
      case (mState)
        0: if (start) begin
             mState = 1; mT = 0; mRep = 0; mErr = 0; mLarge = largePage; mSec = sectorIdx;
           end
        1: begin
             if (spareCount == 8'd4) begin
               expDone = 1; expOut = mErr ? 2 : (mRep ? 1 : 0); expRel = !mErr; mState = 0;
             end else if (mT >= LIMIT) begin
               expDone = 1; expOut = 3; expRel = 1; mState = 0;
             end else if (eccDone && !eccFail) begin
               for (int j = 0; j < 3; j++) begin
                 automatic logic [31:0] w = eccResult[j*32 +: 32];
                 automatic int a = (mLarge ? mSec * 512 + int'(w[31:16]) : int'(w[31:16])) % BUFN;
                 gold[a] = gold[a] ^ w[7:0];
               end
               mRep = 1; mCnt = 6; mState = 2;
             end else if (eccDone && eccFail) begin
               automatic int k = firstDirty(mLarge ? mSec * 512 : 0);
               if (k >= 0) begin mErr = 1; mCnt = k + 2; end
               else mCnt = 513;
               mState = 2;
             end
             mT++;
           end
        2: begin mCnt--; if (mCnt == 0) mState = 3; mT++; end
        default: begin mState = 1; mT++; end
      endcase
      expBusy  = (mState != 0);
      expClear = (mState == 3);
    end
  end

  // per-clock comparison
  always @(negedge clk) begin
    if (rstN && !summaryDone) begin
      compared++;
      if (busy !== expBusy || eccClear !== expClear || outDone !== expDone) begin
        mismatched++;
        $display("FAIL %s busy/clear/done act=%b%b%b exp=%b%b%b at %0t", reqTag,
                 busy, eccClear, outDone, expBusy, expClear, expDone, $time);
      end
      if (expDone) begin
        compared++;
        if (outcome !== 2'(expOut) || spareRelease !== expRel) begin
          mismatched++;
          $display("FAIL %s R9 outcome/release act=%0d/%b exp=%0d/%b", reqTag,
                   outcome, spareRelease, expOut, expRel);
        end
      end
    end
  end

  // ---------------- helpers ----------------
  int lastOut = -1;
  bit lastRel = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic writeByte(input int a, input logic [7:0] d);
    @(negedge clk); hostEn = 1; hostWe = 1; hostAddr = 11'(a); hostWdata = d;
    @(negedge clk); hostEn = 0; hostWe = 0;
  endtask

  task automatic readByte(input int a, output logic [7:0] d);
    @(negedge clk); hostEn = 1; hostWe = 0; hostAddr = 11'(a);
    @(negedge clk); hostEn = 0; d = hostRdata;
  endtask

  task automatic checkByte(input int a, input int exp, input string tag);
    logic [7:0] d;
    readByte(a, d);
    check(d == 8'(exp) && d == gold[a], tag, d, exp);
  endtask

  task automatic beginSector(input bit lg, input int sec);
    @(negedge clk); start = 1; largePage = lg; sectorIdx = 2'(sec);
    @(negedge clk); start = 0;
  endtask

  task automatic decoderEvent(input bit fail, input logic [95:0] words);
    @(negedge clk); eccDone = 1; eccFail = fail; eccResult = words;
    do @(negedge clk); while (!eccClear);
    eccDone = 0; eccFail = 0;
  endtask

  task automatic waitDone();
    do @(negedge clk); while (!outDone);
    lastOut = outcome; lastRel = spareRelease;
    spareCount = 0;
  endtask

  function automatic logic [31:0] word(input int off, input int pat, input int junk);
    return {16'(off), 8'(junk), 8'(pat)};
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!summaryDone) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      summaryDone = 1;
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    for (int a = 0; a < BUFN; a++) gold[a] = initByte(a);
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy == 0 && eccClear == 0 && outDone == 0 && spareRelease == 0, "R1 reset outputs",
          {busy, eccClear, outDone, spareRelease}, 0);
    rstN = 1;
    for (int a = 0; a < BUFN; a++) writeByte(a, initByte(a));

    // R6: sector 0 dirty at byte 40 -> error, no spare release
    reqTag = "R6";
    beginSector(1, 0);
    decoderEvent(1, '0);
    spareCount = 4;
    waitDone();
    check(lastOut == 2, "R6 dirty sector outcome", lastOut, 2);
    check(lastRel == 0, "R9 release withheld on error", lastRel, 0);

    // R2 R3 R4: large page sector 2, duplicate offsets, junk in bits 15:8
    reqTag = "R4";
    beginSector(1, 2);
    decoderEvent(0, {word(100, 8'h3C, 8'hAA), word(5, 8'hF0, 8'h55), word(5, 8'h0F, 8'h99)});
    spareCount = 4;
    waitDone();
    check(lastOut == 1, "R12 repaired outcome", lastOut, 1);
    checkByte(1029, initByte(1029) ^ 8'hFF, "R4 duplicate offset both masks");
    checkByte(1124, initByte(1124) ^ 8'h3C, "R2 R3 large-page patch address");
    checkByte(1028, initByte(1028), "R2 neighbour untouched");

    // R3: small page ignores sectorIdx
    reqTag = "R3";
    beginSector(0, 3);
    decoderEvent(0, {word(301, 8'h02, 0), word(300, 8'h01, 0), word(300, 8'h80, 0)});
    spareCount = 4;
    waitDone();
    checkByte(300, initByte(300) ^ 8'h81, "R3 small-page direct offset");
    checkByte(301, initByte(301) ^ 8'h02, "R3 small-page second offset");
    checkByte(1536 + 300, initByte(1836), "R3 sector window not used");

    // R5 R8: erased sector 1, spare count 3 then 5 before 4
    reqTag = "R5";
    beginSector(1, 1);
    decoderEvent(1, '0);
    reqTag = "R8";
    spareCount = 3; repeat (5) @(negedge clk);
    check(busy == 1, "R8 count 3 keeps waiting", busy, 1);
    spareCount = 5; repeat (5) @(negedge clk);
    check(busy == 1, "R8 count 5 keeps waiting", busy, 1);
    spareCount = 4;
    waitDone();
    check(lastOut == 0, "R5 erased sector success", lastOut, 0);
    check(lastRel == 1, "R9 release on success", lastRel, 1);

    // R12: correction then dirty uncorrectable in sector 3 -> error wins
    reqTag = "R12";
    beginSector(1, 3);
    decoderEvent(0, {word(9, 8'h01, 0), word(8, 8'h01, 0), word(2, 8'h01, 0)});
    decoderEvent(1, '0);
    spareCount = 4;
    waitDone();
    check(lastOut == 2, "R12 error over repaired", lastOut, 2);
    checkByte(1538, initByte(1538) ^ 8'h01, "R7 R12 patch kept before fail");

    // R10 R11: no completion -> timeout; host write while busy ignored
    reqTag = "R10";
    beginSector(1, 1);
    writeByte(600, 8'h00);
    waitDone();
    check(lastOut == 3, "R10 timeout outcome", lastOut, 3);
    check(lastRel == 1, "R9 release on timeout", lastRel, 1);
    checkByte(600, 8'hFF, "R11 busy host write ignored");

    // R12: no events -> success
    reqTag = "R12";
    beginSector(1, 2);
    spareCount = 4;
    waitDone();
    check(lastOut == 0, "R12 plain success", lastOut, 0);

    repeat (3) @(negedge clk);
    if (!summaryDone) begin
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      summaryDone = 1;
    end
    $finish;
  end
endmodule